// File: doc/BRIEF.md
# Sampled Tri-State Phase-Frequency Detector

This block compares a reference clock with a divided feedback clock inside a fast synchronous system-clock domain. Both inputs are treated as asynchronous. Each passes through a synchroniser chain and an edge detector, and the resulting single-cycle event pulses drive a saturating three-valued state: −1 (feedback leads), 0 (neutral) and +1 (reference leads). A reference event moves the state one step up. A feedback event moves it one step down. When both events land in the same system-clock cycle, the state does not change.

The state is decoded into UP and DN pulse outputs and into a two-bit drive request for a downstream charge pump. The enable bit marks an active drive and the polarity bit selects source or sink. A parameter chooses whether rising or falling input transitions count as events, and the same choice applies to both inputs.

Top module: `tri_pfd`

## Requirements
- R1: A synchronous active-high reset on `rst` puts the detector in the neutral state: `up_o`=0, `dn_o`=0, `drv_en_o`=0.
- R2: A reference event from the neutral state moves the detector to +1 (`up_o`=1, `dn_o`=0). From −1 it moves the detector to neutral.
- R3: A reference event while at +1 leaves the detector at +1.
- R4: A feedback event from +1 moves the detector to neutral. From neutral it moves the detector to −1 (`up_o`=0, `dn_o`=1).
- R5: A feedback event while at −1 leaves the detector at −1.
- R6: `up_o` and `dn_o` are never both 1.
- R7: When reference and feedback events fall in the same system-clock cycle, the detector keeps its current state.
- R8: The drive request is `drv_en_o`=1, `drv_pol_o`=1 at +1 (source), `drv_en_o`=1, `drv_pol_o`=0 at −1 (sink), and `drv_en_o`=0 (high impedance) at neutral.
- R9: With the default two synchroniser stages, an input transition set up before rising clock edge k changes the outputs at edge k+2 and not before. Each event lasts exactly one system-clock cycle.
- R10: With `ACTIVE_RISING`=1 only 0→1 input transitions are events. With `ACTIVE_RISING`=0 only 1→0 transitions are events. The opposite transition has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than both inputs |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock |
| fb_in | input | 1 | Asynchronous divided feedback clock |
| up_o | output | 1 | High while the detector is at +1 |
| dn_o | output | 1 | High while the detector is at −1 |
| drv_en_o | output | 1 | Charge-pump drive enable; low means high impedance |
| drv_pol_o | output | 1 | Drive polarity: 1 source, 0 sink; don't-care when disabled |

## Verification
The embedded properties check, on every cycle, that UP and DN are never high together, that saturation holds at both ends of the range, that coincident events leave the state alone, that a disabled drive coincides with both pulse outputs low, and that each event is a one-cycle pulse. The directed scenarios are the only place where the exact two-cycle synchroniser latency is seen at the pins, and the only place where the full walk across all three states is checked. They are also the only place where the inactive edge direction is shown to have no effect, for both parameter settings, and where a reset in the middle of operation is shown to return the detector to neutral.

// File: rtl/tri_pfd_pkg.sv
package tri_pfd_pkg;

    // Two-bit phase state; code 2'b11 is never entered by a legal step
    typedef enum logic [1:0] {
        ST_ZERO = 2'b00,
        ST_LEAD = 2'b01,
        ST_LAG  = 2'b10,
        ST_BAD  = 2'b11
    } pfd_state_e;

    typedef struct packed {
        logic en;   // 1: charge pump driven, 0: high impedance
        logic pol;  // 1: source, 0: sink
    } pump_drive_t;

    // One step of the saturating up/down machine
    function automatic pfd_state_e step_state(input pfd_state_e cur,
                                              input logic       ref_ev,
                                              input logic       fb_ev);
        pfd_state_e nxt;
        nxt = cur;
        case (cur)
            ST_ZERO: begin
                if (ref_ev && !fb_ev)      nxt = ST_LEAD;
                else if (fb_ev && !ref_ev) nxt = ST_LAG;
            end
            ST_LEAD: begin
                if (fb_ev && !ref_ev)      nxt = ST_ZERO;
            end
            ST_LAG: begin
                if (ref_ev && !fb_ev)      nxt = ST_ZERO;
            end
            default: nxt = ST_ZERO;
        endcase
        return nxt;
    endfunction

    function automatic pump_drive_t drive_of(input pfd_state_e st);
        pump_drive_t d;
        d.en  = (st == ST_LEAD) || (st == ST_LAG);
        d.pol = (st == ST_LEAD);
        return d;
    endfunction

endpackage

// File: rtl/pfd_edge_sampler.sv
module pfd_edge_sampler #(
    parameter int SYNC_STAGES   = 2,
    parameter bit ACTIVE_RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic event_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], async_in};
            hist_q <= sync_q[MSB];
        end
    end

    generate
        if (ACTIVE_RISING) begin : g_rise
            assign event_o = sync_q[MSB] & ~hist_q;
        end else begin : g_fall
            assign event_o = ~sync_q[MSB] & hist_q;
        end
    endgenerate

    AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        event_o |=> !event_o); // R9

endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core
    import tri_pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_ev,
    input  logic       fb_ev,
    output pfd_state_e state_o
);
    pfd_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ZERO;
        else     state_q <= step_state(state_q, ref_ev, fb_ev);
    end

    assign state_o = state_q;

    AST_RESET_NEUTRAL: assert property (@(posedge clk)
        rst |=> state_q == ST_ZERO); // R1
    AST_REF_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ZERO && ref_ev && !fb_ev) |=> state_q == ST_LEAD); // R2
    AST_LEAD_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD && ref_ev && !fb_ev) |=> state_q == ST_LEAD); // R3
    AST_FB_FROM_LEAD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD && fb_ev && !ref_ev) |=> state_q == ST_ZERO); // R4
    AST_LAG_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAG && fb_ev && !ref_ev) |=> state_q == ST_LAG); // R5
    AST_COINCIDENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ref_ev && fb_ev) |=> $stable(state_q)); // R7
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_BAD); // R6

endmodule

// File: rtl/pfd_drive_encoder.sv
module pfd_drive_encoder
    import tri_pfd_pkg::*;
(
    input  pfd_state_e  state_i,
    output logic        up_o,
    output logic        dn_o,
    output pump_drive_t drive_o
);
    always_comb begin
        up_o    = (state_i == ST_LEAD);
        dn_o    = (state_i == ST_LAG);
        drive_o = drive_of(state_i);
    end

endmodule

// File: rtl/tri_pfd.sv
module tri_pfd
    import tri_pfd_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter bit ACTIVE_RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic up_o,
    output logic dn_o,
    output logic drv_en_o,
    output logic drv_pol_o
);
    logic        ref_ev;
    logic        fb_ev;
    pfd_state_e  state;
    pump_drive_t drive;

    pfd_edge_sampler #(.SYNC_STAGES(SYNC_STAGES), .ACTIVE_RISING(ACTIVE_RISING)) u_ref_sampler (
        .clk(clk), .rst(rst), .async_in(ref_in), .event_o(ref_ev)
    );

    pfd_edge_sampler #(.SYNC_STAGES(SYNC_STAGES), .ACTIVE_RISING(ACTIVE_RISING)) u_fb_sampler (
        .clk(clk), .rst(rst), .async_in(fb_in), .event_o(fb_ev)
    );

    pfd_state_core u_core (
        .clk(clk), .rst(rst), .ref_ev(ref_ev), .fb_ev(fb_ev), .state_o(state)
    );

    pfd_drive_encoder u_encoder (
        .state_i(state), .up_o(up_o), .dn_o(dn_o), .drive_o(drive)
    );

    assign drv_en_o  = drive.en;
    assign drv_pol_o = drive.pol;

    AST_NO_BOTH_PULSES: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o)); // R6
    AST_HIZ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!up_o && !dn_o) |-> !drv_en_o); // R8
    AST_SOURCE_ON_UP: assert property (@(posedge clk) disable iff (rst)
        up_o |-> (drv_en_o && drv_pol_o)); // R8

endmodule

// File: tb/tri_pfd_bench.sv
module tri_pfd_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, fb_in = 1'b0;
    logic ref_f = 1'b0, fb_f = 1'b0;
    logic up_o, dn_o, drv_en_o, drv_pol_o;
    logic up_f, dn_f, en_f, pol_f;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    tri_pfd u_tri_pfd (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .up_o(up_o), .dn_o(dn_o), .drv_en_o(drv_en_o), .drv_pol_o(drv_pol_o)
    );

    tri_pfd #(.ACTIVE_RISING(1'b0)) u_tri_pfd_fall (
        .clk(clk), .rst(rst), .ref_in(ref_f), .fb_in(fb_f),
        .up_o(up_f), .dn_o(dn_f), .drv_en_o(en_f), .drv_pol_o(pol_f)
    );

    // expected: 1 = +1, 0 = neutral, -1 = -1 ; checks UP/DN and drive (R6, R8)
    task automatic expect_state(input int exp, input string req);
        logic [3:0] act, want;
        act  = {up_o, dn_o, drv_en_o, (drv_en_o ? drv_pol_o : 1'b0)};
        want = (exp > 0) ? 4'b1011 : (exp < 0) ? 4'b0110 : 4'b0000;
        checks++;
        if (act !== want) begin
            failures++;
            $display("FAIL %s up/dn/en/pol actual=%b expected=%b", req, act, want);
        end
        checks++;
        if (up_o && dn_o) begin
            failures++;
            $display("FAIL R6 both pulses high actual=%b%b expected=not 11", up_o, dn_o);
        end
    endtask

    task automatic expect_fall(input int exp, input string req);
        logic [1:0] act, want;
        act  = {up_f, dn_f};
        want = (exp > 0) ? 2'b10 : (exp < 0) ? 2'b01 : 2'b00;
        checks++;
        if (act !== want) begin
            failures++;
            $display("FAIL %s falling-mode up/dn actual=%b expected=%b", req, act, want);
        end
    endtask

    // drive inputs at a falling edge, wait for the result to settle
    task automatic apply(input logic r, input logic f);
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
        repeat (3) @(negedge clk);
    endtask

    task automatic apply_fall(input logic r, input logic f);
        @(negedge clk);
        ref_f = r;
        fb_f  = f;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_state(0, "R1 reset");
        expect_fall(0, "R1 reset falling");
    endtask

    task automatic t_latency();
        @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        expect_state(0, "R9 one edge after");
        @(negedge clk);
        expect_state(0, "R9 two edges after");
        @(negedge clk);
        expect_state(1, "R9/R2 three edges after");
        apply(1'b0, 1'b0);
        expect_state(1, "R10 falling ref ignored");
    endtask

    task automatic t_walk();
        apply(1'b1, 1'b0); expect_state(1, "R3 saturate +1");
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1); expect_state(0, "R4 +1 to 0");
        apply(1'b0, 1'b0); expect_state(0, "R10 falling fb ignored");
        apply(1'b0, 1'b1); expect_state(-1, "R4/R8 0 to -1");
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1); expect_state(-1, "R5 saturate -1");
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0); expect_state(0, "R2 -1 to 0");
        apply(1'b0, 1'b0);
    endtask

    task automatic t_coincident();
        apply(1'b1, 1'b1); expect_state(0, "R7 both at neutral");
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0); expect_state(1, "R2 setup +1");
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b1); expect_state(1, "R7 both at +1");
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1); expect_state(0, "R4 back to 0");
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1); expect_state(-1, "R4 setup -1");
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b1); expect_state(-1, "R7 both at -1");
        apply(1'b0, 1'b0);
    endtask

    task automatic t_falling_mode();
        apply_fall(1'b1, 1'b0); expect_fall(0, "R10 rising ref ignored");
        apply_fall(1'b0, 1'b0); expect_fall(1, "R10 falling ref counts");
        apply_fall(1'b0, 1'b1); expect_fall(1, "R10 rising fb ignored");
        apply_fall(1'b0, 1'b0); expect_fall(0, "R10 falling fb counts");
    endtask

    task automatic t_mid_reset();
        apply(1'b0, 1'b1); expect_state(-1, "R4 before reset");
        apply(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_state(0, "R1 reset mid-run");
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_walk();
        t_coincident();
        t_falling_mode();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule